// File: doc/BRIEF.md
# Table-Read Lookup Unit

This unit executes table-read operations against a 16-bit-wide program memory of 8192 words, split into 256-word pages. Software first writes an 8-bit table pointer through a small register interface. A table-read request then selects one word: either in the page that holds the current program counter, or in the final page of memory. The pointer supplies the word offset inside that page.

The fetched word is split into two bytes. The low byte goes out on a data-memory write port, addressed by the destination that came with the request. The high byte is latched into a read-only high-byte register, which sits at a fixed register address. Every table read overwrites that register. A read made inside an interrupt routine therefore destroys the value that the main routine left there.

Each read has two phases. In the address phase the ROM port is driven. In the data phase the data memory is written and the high byte is captured. A busy output stays high for both phases so that the instruction fetch can stall.

Top module: `tbl_read_unit`

## Requirements
- R1: After a synchronous reset, the table pointer reads 0x00 at register address 0x07, the high-byte register reads 0x00 at address 0x08, and busy is low.
- R2: A register write to address 0x07 loads the table pointer, and a read of address 0x07 returns the stored value.
- R3: A register write to address 0x08 is ignored, and the high-byte register keeps its value.
- R4: A current-page read (page select 0) drives ROM address {pc[12:8], pointer}.
- R5: A last-page read (page select 1) drives ROM address {5'b11111, pointer}, whatever the PC holds.
- R6: In the data phase, dm_we is high for exactly one cycle, dm_addr equals the destination captured with the request, and dm_wdata equals bits [7:0] of the ROM word.
- R7: At the end of the data phase, bits [15:8] of the ROM word are loaded into the high-byte register, overwriting any earlier value.
- R8: busy is high for exactly two cycles per read. rom_rd_en is high only in the first of them, the address phase, and the ROM returns data one cycle after its address.
- R9: A request asserted while busy is high is ignored and does not change the read in progress.
- R10: A register read of any address other than 0x07 or 0x08 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tr_start | input | 1 | Table-read request |
| tr_last | input | 1 | Page select: 1 = last page, 0 = current page |
| tr_dest | input | 8 | Data-memory destination for the low byte |
| pc | input | 13 | Current program counter |
| rom_addr | output | 13 | ROM word address |
| rom_rd_en | output | 1 | ROM read strobe (address phase) |
| rom_rdata | input | 16 | ROM word, valid one cycle after the address |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (low byte) |
| busy | output | 1 | Read in progress; stalls instruction fetch |

## Verification
A request sampled at clock edge E0 puts its ROM address and rom_rd_en on the outputs right after E0. The low-byte write is presented after E1. The high-byte register and the falling busy become visible after E2. Register writes show on reg_rdata right after the edge that samples them. The bench drives every input on the falling edge and checks each result on the falling edge of the cycle it is due in, using a ROM model that returns its word one edge after the address. That model encodes the address in the data, so a wrong page or offset shows up in both bytes.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    localparam int unsigned ROM_AW_DEF   = 13;
    localparam int unsigned WORD_W_DEF   = 16;
    localparam int unsigned BYTE_W_DEF   = 8;
    localparam int unsigned PAGE_WORDS_DEF = 256;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } tr_state_e;

    // true when a register access hits the given decoded address
    function automatic logic addr_hit(input logic [7:0] a, input logic [7:0] target);
        return a == target;
    endfunction
endpackage

// File: rtl/tbl_regs.sv
module tbl_regs #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned REG_AW   = 8,
    parameter int unsigned PTR_W    = 8,
    parameter logic [7:0]  PTR_ADDR = 8'h07,
    parameter logic [7:0]  HI_ADDR  = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              hi_load,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [PTR_W-1:0]  tblp
);
    import tbl_pkg::*;

    logic [BYTE_W-1:0] hi_q;
    logic              ptr_sel;
    logic              hi_sel;

    assign ptr_sel = addr_hit(8'(addr), PTR_ADDR);
    assign hi_sel  = addr_hit(8'(addr), HI_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            tblp <= '0;
            hi_q <= '0;
        end else begin
            if (wr_en && ptr_sel) tblp <= wdata[PTR_W-1:0];
            if (hi_load)          hi_q <= hi_in;
        end
    end

    always_comb begin
        rdata = '0;
        if (ptr_sel)     rdata = BYTE_W'(tblp);
        else if (hi_sel) rdata = hi_q;
    end

    // R3 / R7: the high byte only moves on a table-read load
    a_r3_hi_ignores_writes: assert property (@(posedge clk) disable iff (rst)
        !hi_load |=> $stable(hi_q));
    a_r7_hi_takes_rom: assert property (@(posedge clk) disable iff (rst)
        hi_load |=> hi_q == $past(hi_in));
    a_r2_ptr_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_sel) |=> tblp == $past(wdata[PTR_W-1:0]));
endmodule

// File: rtl/tbl_seq.sv
module tbl_seq #(
    parameter int unsigned ROM_AW = 13,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 8,
    parameter int unsigned DM_AW  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              last,
    input  logic [DM_AW-1:0]  dest,
    input  logic [ROM_AW-1:0] pc,
    input  logic [PTR_W-1:0]  tblp,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd_en,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic              dm_we,
    output logic [DM_AW-1:0]  dm_addr,
    output logic [BYTE_W-1:0] dm_wdata,
    output logic              hi_load,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              busy
);
    import tbl_pkg::*;

    localparam int unsigned PAGE_AW = ROM_AW - PTR_W;
    localparam logic [PAGE_AW-1:0] TOP_PAGE = '1;

    tr_state_e         state;
    logic [ROM_AW-1:0] addr_q;
    logic [DM_AW-1:0]  dest_q;
    logic [PAGE_AW-1:0] page;

    assign page = last ? TOP_PAGE : pc[ROM_AW-1:PTR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            dest_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    addr_q <= {page, tblp};
                    dest_q <= dest;
                    state  <= ST_ADDR;
                end
                ST_ADDR: state <= ST_DATA;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rom_addr  = addr_q;
    assign rom_rd_en = state == ST_ADDR;
    assign dm_we     = state == ST_DATA;
    assign dm_addr   = dest_q;
    assign dm_wdata  = rom_rdata[BYTE_W-1:0];
    assign hi_load   = state == ST_DATA;
    assign hi_byte   = rom_rdata[2*BYTE_W-1:BYTE_W];
    assign busy      = state != ST_IDLE;

    a_r8_addr_then_data: assert property (@(posedge clk) disable iff (rst)
        rom_rd_en |=> dm_we && busy);
    a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
        dm_we |=> !dm_we && !busy);
    a_r9_held_during_read: assert property (@(posedge clk) disable iff (rst)
        rom_rd_en |=> $stable(rom_addr) && $stable(dm_addr));
    a_r8_start_begins: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> rom_rd_en);
endmodule

// File: rtl/tbl_read_unit.sv
module tbl_read_unit #(
    parameter int unsigned ROM_AW     = tbl_pkg::ROM_AW_DEF,
    parameter int unsigned WORD_W     = tbl_pkg::WORD_W_DEF,
    parameter int unsigned BYTE_W     = tbl_pkg::BYTE_W_DEF,
    parameter int unsigned PAGE_WORDS = tbl_pkg::PAGE_WORDS_DEF,
    parameter int unsigned REG_AW     = 8,
    parameter int unsigned DM_AW      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              tr_start,
    input  logic              tr_last,
    input  logic [DM_AW-1:0]  tr_dest,
    input  logic [ROM_AW-1:0] pc,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd_en,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic              dm_we,
    output logic [DM_AW-1:0]  dm_addr,
    output logic [BYTE_W-1:0] dm_wdata,
    output logic              busy
);
    localparam int unsigned PTR_W = $clog2(PAGE_WORDS);

    logic [PTR_W-1:0]  tblp;
    logic              hi_load;
    logic [BYTE_W-1:0] hi_byte;

    tbl_regs #(
        .BYTE_W (BYTE_W),
        .REG_AW (REG_AW),
        .PTR_W  (PTR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .hi_load (hi_load),
        .hi_in   (hi_byte),
        .tblp    (tblp)
    );

    tbl_seq #(
        .ROM_AW (ROM_AW),
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .PTR_W  (PTR_W),
        .DM_AW  (DM_AW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (tr_start),
        .last      (tr_last),
        .dest      (tr_dest),
        .pc        (pc),
        .tblp      (tblp),
        .rom_addr  (rom_addr),
        .rom_rd_en (rom_rd_en),
        .rom_rdata (rom_rdata),
        .dm_we     (dm_we),
        .dm_addr   (dm_addr),
        .dm_wdata  (dm_wdata),
        .hi_load   (hi_load),
        .hi_byte   (hi_byte),
        .busy      (busy)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> !busy && !dm_we && !rom_rd_en);
endmodule

// File: tb/tbl_read_unit_test.sv
module tbl_read_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        tr_start;
    logic        tr_last;
    logic [7:0]  tr_dest;
    logic [12:0] pc;
    logic [12:0] rom_addr;
    logic        rom_rd_en;
    logic [15:0] rom_rdata;
    logic        dm_we;
    logic [7:0]  dm_addr;
    logic [7:0]  dm_wdata;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // synchronous ROM model: word encodes its own address
    always_ff @(posedge clk)
        if (rom_rd_en) rom_rdata <= {3'b101, rom_addr};

    tbl_read_unit uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tr_start(tr_start), .tr_last(tr_last), .tr_dest(tr_dest), .pc(pc),
        .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .rom_rdata(rom_rdata),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    // one full table read, checking every phase
    task automatic table_read(input string tag, input logic last, input logic [7:0] dest,
                              input logic [12:0] pcv, input logic [12:0] exp_addr);
        logic [7:0] v;
        tr_start = 1'b1; tr_last = last; tr_dest = dest; pc = pcv;
        @(posedge clk); @(negedge clk);              // after E0: address phase
        tr_start = 1'b0;
        chk({tag, " R8 busy addr phase"}, busy, 1);
        chk({tag, " R8 rom_rd_en"}, rom_rd_en, 1);
        chk({tag, " ROM address"}, rom_addr, exp_addr);
        @(posedge clk); @(negedge clk);              // after E1: data phase
        chk({tag, " R8 busy data phase"}, busy, 1);
        chk({tag, " R8 rd_en low in data"}, rom_rd_en, 0);
        chk({tag, " R6 dm_we"}, dm_we, 1);
        chk({tag, " R6 dm_addr"}, dm_addr, dest);
        chk({tag, " R6 dm_wdata"}, dm_wdata, exp_addr[7:0]);
        @(posedge clk); @(negedge clk);              // after E2: done
        chk({tag, " R8 busy cleared"}, busy, 0);
        chk({tag, " R6 dm_we single"}, dm_we, 0);
        reg_read(8'h08, v);
        chk({tag, " R7 high byte"}, v, {3'b101, exp_addr[12:8]});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        reg_read(8'h07, v); chk("R1 pointer reset", v, 8'h00);
        reg_read(8'h08, v); chk("R1 high byte reset", v, 8'h00);
        chk("R1 busy reset", busy, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        reg_write(8'h07, 8'h3C);
        reg_read(8'h07, v); chk("R2 pointer readback", v, 8'h3C);
        reg_write(8'h08, 8'hFF);
        reg_read(8'h08, v); chk("R3 high byte write ignored", v, 8'h00);
        reg_read(8'h10, v); chk("R10 unmapped read", v, 8'h00);
        reg_read(8'h06, v); chk("R10 unmapped read 06", v, 8'h00);
    endtask

    task automatic t_reads;
        logic [7:0] v;
        table_read("R4 current page", 1'b0, 8'h21, 13'h0A57, 13'h0A3C);
        table_read("R5 last page", 1'b1, 8'h22, 13'h0A57, 13'h1F3C);
        reg_write(8'h08, 8'h00);
        reg_read(8'h08, v); chk("R3 write after load ignored", v, 8'hBF);
        reg_write(8'h07, 8'hFF);
        table_read("R4 page edge", 1'b0, 8'h7F, 13'h1234, 13'h12FF);
        reg_write(8'h07, 8'h00);
        table_read("R5 last page zero ptr", 1'b1, 8'h00, 13'h0000, 13'h1F00);
    endtask

    task automatic t_busy_start;
        logic [7:0] v;
        reg_write(8'h07, 8'h45);
        tr_start = 1'b1; tr_last = 1'b0; tr_dest = 8'h11; pc = 13'h0300;
        @(posedge clk); @(negedge clk);
        tr_dest = 8'h99; tr_last = 1'b1; pc = 13'h0700;   // ignored while busy
        chk("R9 addr kept", rom_addr, 13'h0345);
        @(posedge clk); @(negedge clk);
        tr_start = 1'b0;
        chk("R9 dest kept", dm_addr, 8'h11);
        chk("R9 data kept", dm_wdata, 8'h45);
        @(posedge clk); @(negedge clk);
        chk("R9 no restart", busy, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 still idle", busy, 0);
        chk("R9 no extra rom read", rom_rd_en, 0);
        reg_read(8'h08, v); chk("R7 overwrite by later read", v, 8'hA3);
    endtask

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        tr_start = 1'b0; tr_last = 1'b0; tr_dest = 8'h00; pc = '0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_reads();
        t_busy_start();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule